// File: doc/BRIEF.md
# Free-Running Tick Counter with Compare Channels and Watchdog

The block is a 32-bit up-counter that steps once for each cycle in which the tick strobe is high and the run bit is set. Eight compare channels watch the count. A channel latches a status bit when the count becomes equal to its compare value, and that status bit can raise an interrupt. Channel 0 can also be armed as a watchdog. Its hit then produces a one-cycle reset request and sets a sticky reset-cause flag. To keep the watchdog from firing, software keeps moving the channel-0 compare value ahead of the count.

Software reaches the live count through a two-step handshake. Asking for a read starts a short transfer; a busy flag stays high until the transfer ends, and the count register then holds a frozen snapshot. A write to the count register starts a transfer of its own the same way, and the new value reaches the counter when that transfer completes. The reset-cause flag is cleared only by power-on reset or by software writing 1 to it. The ordinary reset, which the watchdog request drives, leaves it alone.

Top module: `ostmr`

## Requirements
- R1: After reset the count, every compare value, status, interrupt enable, watchdog arm, run bit and access flags read 0, and `irq_o` and `wdt_rst_o` are low. After power-on reset the reset-cause flag reads 0.
- R2: While the run bit (control bit 0) is 1, the count grows by 1 on each cycle with `tick_i` high. After 0 is written to the control register, the count no longer changes.
- R3: Writing the control register with bit 1 set starts a snapshot. Access-status bit 1 then reads 1 for SYNC_STAGES (2) cycles. After that, the count register returns the count as it was when the snapshot was taken.
- R4: A write to the count register raises access-status bit 0 for SYNC_STAGES (2) cycles, and the value is loaded when the flag drops. A count write that arrives while bit 0 is high is discarded. A load takes priority over a tick in the same cycle.
- R5: Channel i sets status bit i in the cycle after the count becomes equal to its compare value. Writing 1 to a status bit clears it, and a new hit in the same cycle wins over the clear.
- R6: `irq_o` is high exactly when some status bit and its interrupt-enable bit (same position) are both 1.
- R7: When the watchdog arm bit (bit 0) is 1, a channel-0 hit drives `wdt_rst_o` high for one cycle. When the arm bit is 0, a channel-0 hit sets only status bit 0.
- R8: A watchdog request sets bit 3 of the reset-cause register. Writing 1 to bit 3 clears it, `rst_ni` does not clear it, and only `por_ni` resets it.
- R9: Equality is exact across wrap. A compare value of 1, with the count at 0xFFFFFFFE, hits after three ticks.
- R10: The word addresses are: 0-7 for compare channels 0-7, 8 for count, 9 for status, 10 for watchdog arm, 11 for interrupt enable (8 bits), 12 for control and 13 for access status. The reset-cause register is at 14. Compare values read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset for all state except the reset-cause flag |
| por_ni | input | 1 | Active-low power-on reset for the reset-cause flag |
| tick_i | input | 1 | Count-step strobe |
| sel_i | input | 1 | Register access select |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Compare interrupt |
| wdt_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
Two events can land on the same clock edge: a count load completing at the end of its transfer, and a tick step. The bench holds `tick_i` high with the counter running and writes 500 to the count register. It then times a control write so that it stops the counter and requests a snapshot on the very edge where the load completes. The snapshot must read exactly 500. Any other value shows that the tick won, or that it was added on top of the load.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned NUM_CH = 8;
  localparam int unsigned RST_BIT = 3;

  localparam logic [3:0] A_CNT  = 4'd8;
  localparam logic [3:0] A_STAT = 4'd9;
  localparam logic [3:0] A_WDEN = 4'd10;
  localparam logic [3:0] A_IEN  = 4'd11;
  localparam logic [3:0] A_CTRL = 4'd12;
  localparam logic [3:0] A_ACC  = 4'd13;
  localparam logic [3:0] A_RSTS = 4'd14;
endpackage

// File: rtl/ostmr_counter.sv
module ostmr_counter #(
  parameter int unsigned CW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          rd_req_i,
  input  logic          wr_req_i,
  input  logic [CW-1:0] wr_data_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] snap_o,
  output logic          rd_busy_o,
  output logic          wr_busy_o
);
  localparam int unsigned SW = $clog2(SYNC_STAGES + 1);
  localparam logic [SW-1:0] LEN = SW'(SYNC_STAGES);
  localparam logic [SW-1:0] ONE = SW'(1);

  logic [SW-1:0] rd_cnt, wr_cnt;
  logic [CW-1:0] cnt, snap, wr_hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt  <= '0;
      wr_cnt  <= '0;
      cnt     <= '0;
      snap    <= '0;
      wr_hold <= '0;
    end else begin
      if (rd_req_i && rd_cnt == '0) rd_cnt <= LEN;
      else if (rd_cnt != '0)        rd_cnt <= rd_cnt - ONE;
      if (rd_cnt == ONE) snap <= cnt;

      if (wr_req_i && wr_cnt == '0) begin
        wr_cnt  <= LEN;
        wr_hold <= wr_data_i;
      end else if (wr_cnt != '0) begin
        wr_cnt <= wr_cnt - ONE;
      end
      // load wins over a tick in the same cycle
      if (wr_cnt == ONE)         cnt <= wr_hold;
      else if (en_i && tick_i)   cnt <= cnt + 1'b1;
    end
  end

  assign cnt_o     = cnt;
  assign snap_o    = snap;
  assign rd_busy_o = (rd_cnt != '0);
  assign wr_busy_o = (wr_cnt != '0);
endmodule

// File: rtl/ostmr_match.sv
module ostmr_match #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cmp_i,
  output logic          hit_o
);
  logic eq, eq_q;
  assign eq = (cnt_i == cmp_i);

  // reset to 1: count and compare are both 0 out of reset, not a hit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b1;
    else         eq_q <= eq;
  end

  assign hit_o = eq & ~eq_q;
endmodule

// File: rtl/ostmr.sv
module ostmr
  import ostmr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_ni,
  input  logic          tick_i,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [3:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          wdt_rst_o
);
  logic [DW-1:0]     cmp_q [NUM_CH];
  logic [NUM_CH-1:0] stat_q, ien_q, hit, stat_clr;
  logic              wden_q, en_q, wdt_q, rsts_q;
  logic [DW-1:0]     cnt, snap;
  logic              rd_busy, wr_busy;
  logic              we;

  assign we       = sel_i & wr_i;
  assign stat_clr = (we && addr_i == A_STAT) ? wdata_i[NUM_CH-1:0] : '0;

  ostmr_counter #(.CW(DW), .SYNC_STAGES(SYNC_STAGES)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .en_i      (en_q),
    .rd_req_i  (we && addr_i == A_CTRL && wdata_i[1]),
    .wr_req_i  (we && addr_i == A_CNT),
    .wr_data_i (wdata_i),
    .cnt_o     (cnt),
    .snap_o    (snap),
    .rd_busy_o (rd_busy),
    .wr_busy_o (wr_busy)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ostmr_match #(.CW(DW)) u_match (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_i  (cnt),
      .cmp_i  (cmp_q[g]),
      .hit_o  (hit[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             cmp_q[g] <= '0;
      else if (we && addr_i == 4'(g))          cmp_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      ien_q  <= '0;
      wden_q <= 1'b0;
      en_q   <= 1'b0;
      wdt_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | hit;   // hit wins over clear
      wdt_q  <= hit[0] & wden_q;
      if (we && addr_i == A_IEN)  ien_q  <= wdata_i[NUM_CH-1:0];
      if (we && addr_i == A_WDEN) wden_q <= wdata_i[0];
      if (we && addr_i == A_CTRL) en_q   <= wdata_i[0];
    end
  end

  // reset-cause flag lives on the power-on reset only
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                                      rsts_q <= 1'b0;
    else if (hit[0] && wden_q)                        rsts_q <= 1'b1;
    else if (we && addr_i == A_RSTS && wdata_i[RST_BIT]) rsts_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && !wr_i) begin
      if (!addr_i[3]) rdata_o = cmp_q[addr_i[2:0]];
      else begin
        case (addr_i)
          A_CNT:  rdata_o = snap;
          A_STAT: rdata_o[NUM_CH-1:0] = stat_q;
          A_WDEN: rdata_o[0] = wden_q;
          A_IEN:  rdata_o[NUM_CH-1:0] = ien_q;
          A_CTRL: rdata_o[1:0] = {rd_busy, en_q};
          A_ACC:  rdata_o[1:0] = {rd_busy, wr_busy};
          A_RSTS: rdata_o[RST_BIT] = rsts_q;
          default: rdata_o = '0;
        endcase
      end
    end
  end

  assign irq_o     = |(stat_q & ien_q);
  assign wdt_rst_o = wdt_q;
endmodule

// File: rtl/ostmr_chk.sv
module ostmr_chk #(
  parameter int unsigned CW = 32,
  parameter int unsigned NCH = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           en_i,
  input logic [CW-1:0]  cnt_i,
  input logic           rd_busy_i,
  input logic           wr_busy_i,
  input logic           wdt_i,
  input logic           wden_i,
  input logic           rsts_i,
  input logic [NCH-1:0] stat_i,
  input logic [NCH-1:0] stat_clr_i
);
  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_busy_i) |=> $stable(cnt_i));

  // R3
  rd_busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_busy_i) |=> rd_busy_i);

  // R4
  wr_busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_busy_i) |=> wr_busy_i);

  // R5
  stat_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr_i == '0) |=> ((stat_i & $past(stat_i)) == $past(stat_i)));

  // R7
  wdt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_i |=> !wdt_i);

  // R7
  wdt_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_i |-> $past(wden_i));

  // R8
  rsts_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_i |-> rsts_i);
endmodule

bind ostmr ostmr_chk #(.CW(ostmr_pkg::DW), .NCH(ostmr_pkg::NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_q),
  .cnt_i      (cnt),
  .rd_busy_i  (rd_busy),
  .wr_busy_i  (wr_busy),
  .wdt_i      (wdt_q),
  .wden_i     (wden_q),
  .rsts_i     (rsts_q),
  .stat_i     (stat_q),
  .stat_clr_i (stat_clr)
);

// File: tb/ostmr_test.sv
module ostmr_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0, por_ni = 1'b0;
  logic        tick_i = 1'b0, sel_i = 1'b0, wr_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, wdt_rst_o;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 1'b0;

  localparam logic [3:0] CNT = 4'd8, STAT = 4'd9, WDEN = 4'd10, IEN = 4'd11,
                         CTRL = 4'd12, ACC = 4'd13, RSTS = 4'd14;

  // table: address, write data, expected readback
  localparam int NV = 10;
  localparam logic [3:0]  TV_A [NV] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, IEN, WDEN};
  localparam logic [31:0] TV_D [NV] = '{32'h1000_0000, 32'h1000_0011, 32'h1000_0022, 32'h1000_0033,
                                        32'h1000_0044, 32'h1000_0055, 32'h1000_0066, 32'h1000_0077,
                                        32'hFFFF_FF5A, 32'hFFFF_FFFE};
  localparam logic [31:0] TV_E [NV] = '{32'h1000_0000, 32'h1000_0011, 32'h1000_0022, 32'h1000_0033,
                                        32'h1000_0044, 32'h1000_0055, 32'h1000_0066, 32'h1000_0077,
                                        32'h0000_005A, 32'h0000_0000};

  ostmr uut (.*);

  always #4 clk_i = ~clk_i;

  always @(negedge clk_i) if (wdt_rst_o) pulses++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    sel_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    sel_i = 1'b1; wr_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    sel_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    peek(a, d);
  endtask

  // stop counter, request snapshot, wait it out, read count
  task automatic readcnt(output logic [31:0] d);
    wr(CTRL, 32'd2);
    repeat (2) @(negedge clk_i);
    peek(CNT, d);
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int p0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1; por_ni = 1'b1;

    // R1 reset state
    rd(ACC, d);  chk("R1 access", d, 0);
    rd(CTRL, d); chk("R1 ctrl", d, 0);
    rd(STAT, d); chk("R1 status", d, 0);
    rd(RSTS, d); chk("R1 reset cause", d, 0);
    rd(CNT, d);  chk("R1 count", d, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 wdt", wdt_rst_o, 0);

    // R10 register map readback
    for (int i = 0; i < NV; i++) begin
      wr(TV_A[i], TV_D[i]);
      rd(TV_A[i], d);
      chk($sformatf("R10 addr %0d", TV_A[i]), d, TV_E[i]);
    end

    // R4 count write handshake; second write while busy is dropped
    wr(CNT, 32'd100);
    peek(ACC, d); chk("R4 write busy", d, 32'h1);
    wr(CNT, 32'd555);
    @(negedge clk_i);
    peek(ACC, d); chk("R4 write busy cleared", d, 0);
    // R3 snapshot handshake
    wr(CTRL, 32'd2);
    peek(ACC, d); chk("R3 read busy", d, 32'h2);
    repeat (2) @(negedge clk_i);
    peek(ACC, d); chk("R3 read busy cleared", d, 0);
    peek(CNT, d); chk("R4 loaded value", d, 100);

    // R2 counting and stop
    wr(CTRL, 32'd1);
    ticks(5);
    readcnt(d); chk("R2 count after 5 ticks", d, 105);
    ticks(3);
    readcnt(d); chk("R2 stopped count", d, 105);

    // R5 / R6 compare status and interrupt
    wr(4'd3, 32'd108);
    wr(IEN, 32'h08);
    wr(CTRL, 32'd1);
    ticks(3);
    repeat (2) @(negedge clk_i);
    peek(STAT, d); chk("R5 status bit 3", d, 32'h08);
    chk("R6 irq on", irq_o, 1);
    wr(CTRL, 32'd0);
    wr(IEN, 32'h00);
    chk("R6 irq masked", irq_o, 0);
    peek(STAT, d); chk("R5 status held", d, 32'h08);
    wr(IEN, 32'h08);
    chk("R6 irq unmasked", irq_o, 1);
    wr(STAT, 32'h08);
    peek(STAT, d); chk("R5 w1c", d, 0);
    chk("R6 irq after clear", irq_o, 0);

    // R4 load wins over tick on the same edge
    wr(CTRL, 32'd1);
    @(negedge clk_i);
    tick_i = 1'b1;
    wr(CNT, 32'd500);
    wr(CTRL, 32'd2);
    tick_i = 1'b0;
    repeat (2) @(negedge clk_i);
    peek(CNT, d); chk("R4 load priority", d, 500);

    // R7 / R8 / R9 armed watchdog across wrap
    wr(CNT, 32'hFFFF_FFFE);
    repeat (2) @(negedge clk_i);
    wr(4'd0, 32'd1);
    wr(WDEN, 32'd1);
    wr(CTRL, 32'd1);
    p0 = pulses;
    ticks(3);
    repeat (3) @(negedge clk_i);
    chk("R7 R9 one pulse", 32'(pulses - p0), 1);
    peek(STAT, d); chk("R9 channel 0 status", d, 32'h01);
    peek(RSTS, d); chk("R8 cause set", d, 32'h08);
    wr(RSTS, 32'h0);
    peek(RSTS, d); chk("R8 write 0 no effect", d, 32'h08);

    // R8 survives ordinary reset
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    rd(RSTS, d); chk("R8 kept over rst", d, 32'h08);
    rd(CTRL, d); chk("R1 ctrl after rst", d, 0);
    wr(RSTS, 32'h08);
    peek(RSTS, d); chk("R8 w1c", d, 0);

    // R7 disarmed watchdog: status only
    wr(4'd0, 32'd3);
    wr(CTRL, 32'd1);
    p0 = pulses;
    ticks(5);
    repeat (3) @(negedge clk_i);
    chk("R7 no pulse when disarmed", 32'(pulses - p0), 0);
    peek(STAT, d); chk("R7 status bit 0", d, 32'h01);
    peek(RSTS, d); chk("R8 not set when disarmed", d, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule